// File: doc/BRIEF.md
# Programmable Window Gate Generator

This block produces a periodic window gate for a pulse counter that measures frequency. While the gate is high, counting is allowed. While it is low, counting stops. The high phase lasts (16 − Ta) time units and the low phase lasts (16 − Tb) time units, where Ta and Tb are separate 4-bit settings written through their own strobes.

The time unit comes from a free-running binary divider that advances on each pulse of the source-tick input. A 2-bit tap code chooses a unit of 2^(BASE_SHIFT+code) source ticks. A fast-oscillator build uses BASE_SHIFT = 12 and a slow-oscillator build uses BASE_SHIFT = 4.

Raising the run input starts the gate in its high phase on the next unit boundary. Dropping run stops the gate and clears it. The gate level comes with one-cycle rise and fall pulses, which a downstream counter and interrupt logic can use.

Top module: `wgate_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, gate, gate_rise and gate_fall are all 0.
- R2: Each high phase of the gate lasts (16 − Ta) units, where Ta is the 4-bit high-phase setting. A Ta of 0 gives 16 units.
- R3: Each low phase of the gate lasts (16 − Tb) units, where Tb is the 4-bit low-phase setting. A Tb of 0 gives 16 units.
- R4: One unit is 2^(BASE_SHIFT + c) source ticks, where c is the tap code: 0, 1 or 2. Tap code 3 behaves as code 2.
- R5: Only clock cycles in which src_tick is 1 advance the unit divider. With src_tick high on one cycle in two, every phase lasts twice as many clock cycles.
- R6: After run rises while the gate is idle, the gate goes high within one unit of clock cycles: at least 1 cycle and at most 2^(BASE_SHIFT+c) source ticks later. That first phase is a full high phase.
- R7: When run is 0, the gate is 0 from the next cycle on. If the gate was high, gate_fall pulses in that cycle. No rise occurs while run stays 0.
- R8: Ta is sampled when a high phase begins. A Ta write during a high phase leaves that phase's length unchanged and applies from the next high phase.
- R9: Tb is sampled when a low phase begins. A Tb write during a low phase leaves that phase's length unchanged and applies from the next low phase.
- R10: gate_rise is 1 in exactly the first cycle in which gate is 1. gate_fall is 1 in exactly the first cycle in which gate is 0 after being 1. Neither lasts more than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_tick | input | 1 | Source-clock enable that advances the unit divider |
| tap_sel | input | 2 | Unit tap code c: unit is 2^(BASE_SHIFT+c) ticks |
| run | input | 1 | Start (1) or stop (0) the gate |
| ta_val | input | 4 | High-phase setting Ta |
| ta_wr | input | 1 | Write strobe for ta_val |
| tb_val | input | 4 | Low-phase setting Tb |
| tb_wr | input | 1 | Write strobe for tb_val |
| gate | output | 1 | Window gate level |
| gate_rise | output | 1 | One-cycle pulse on the first high cycle |
| gate_fall | output | 1 | One-cycle pulse on the first low cycle |

## Verification
The hardest situation to reach from the ports is a setting write that lands in the middle of the very phase it governs. Only the lengths of the following phases show that the running phase was left alone.

The stimulus first waits for a gate edge, then issues the Ta or Tb strobe a few cycles later. It then measures the current phase and the next phase of the same kind as edge-to-edge cycle counts.

A stop issued in the middle of a high phase is reached the same way. After the stop, the bench checks the forced fall pulse and the absence of any rise.

// File: rtl/wgate_pkg.sv
package wgate_pkg;

  typedef int unsigned uint_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HIGH = 2'd1,
    PH_LOW  = 2'd2
  } phase_e;

  // Phase length in units: full field range minus the programmed value
  function automatic uint_t phase_units(uint_t field, uint_t field_w);
    return (uint_t'(1) << field_w) - field;
  endfunction

  // Tap codes past the last implemented tap select the last tap
  function automatic uint_t clamp_tap(uint_t code, uint_t num_taps);
    return (code >= num_taps) ? num_taps - 1 : code;
  endfunction

endpackage

// File: rtl/wgate_prescaler.sv
module wgate_prescaler #(
  parameter int BASE_SHIFT = 12,
  parameter int NUM_TAPS   = 3,
  parameter int SEL_W      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_tick,
  input  logic [SEL_W-1:0] tap_sel,
  output logic             unit_tick
);
  import wgate_pkg::*;

  localparam int DIV_W = BASE_SHIFT + NUM_TAPS;

  logic [DIV_W-1:0]    div_q;
  logic [NUM_TAPS-1:0] tap_hit;
  int                  sel_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else if (src_tick) div_q <= div_q + 1'b1;
  end

  // A tap fires on the source tick that wraps its low bits
  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    localparam logic [DIV_W-1:0] MASK =
      DIV_W'((64'd1 << (BASE_SHIFT + k)) - 64'd1);
    assign tap_hit[k] = src_tick && ((div_q & MASK) == MASK);
  end

  assign sel_idx = int'(clamp_tap(uint_t'(tap_sel), uint_t'(NUM_TAPS)));

  always_comb begin
    unit_tick = 1'b0;
    for (int k = 0; k < NUM_TAPS; k++)
      if (k == sel_idx) unit_tick = tap_hit[k];
  end

  // R5: a unit boundary only ever falls on a source tick
  a_r5_tick_needs_src: assert property (@(posedge clk) disable iff (!rst_n)
    unit_tick |-> src_tick);

endmodule

// File: rtl/wgate_cfg.sv
module wgate_cfg #(
  parameter int FIELD_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FIELD_W-1:0] ta_val,
  input  logic               ta_wr,
  input  logic [FIELD_W-1:0] tb_val,
  input  logic               tb_wr,
  output logic [FIELD_W-1:0] ta_q,
  output logic [FIELD_W-1:0] tb_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ta_q <= '0;
      tb_q <= '0;
    end else begin
      if (ta_wr) ta_q <= ta_val;
      if (tb_wr) tb_q <= tb_val;
    end
  end

endmodule

// File: rtl/wgate_phase_seq.sv
module wgate_phase_seq #(
  parameter int FIELD_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               unit_tick,
  input  logic [FIELD_W-1:0] ta_q,
  input  logic [FIELD_W-1:0] tb_q,
  output logic               gate,
  output logic               gate_rise,
  output logic               gate_fall
);
  import wgate_pkg::*;

  localparam int PHASE_W = FIELD_W + 1;

  phase_e             state_q, state_d;
  logic [PHASE_W-1:0] cnt_q, cnt_d;
  logic [PHASE_W-1:0] len_q, len_d;
  logic [PHASE_W-1:0] ta_len, tb_len;
  logic               phase_done;
  logic               gate_d;
  logic               gate_q, rise_q, fall_q;

  assign ta_len     = PHASE_W'(phase_units(uint_t'(ta_q), uint_t'(FIELD_W)));
  assign tb_len     = PHASE_W'(phase_units(uint_t'(tb_q), uint_t'(FIELD_W)));
  assign phase_done = unit_tick && (cnt_q == len_q - 1'b1);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    len_d   = len_q;
    if (!run) begin
      state_d = PH_IDLE;
      cnt_d   = '0;
    end else begin
      case (state_q)
        PH_IDLE: if (unit_tick) begin
          state_d = PH_HIGH;
          cnt_d   = '0;
          len_d   = ta_len;
        end
        PH_HIGH: if (phase_done) begin
          state_d = PH_LOW;
          cnt_d   = '0;
          len_d   = tb_len;
        end else if (unit_tick) begin
          cnt_d = cnt_q + 1'b1;
        end
        PH_LOW: if (phase_done) begin
          state_d = PH_HIGH;
          cnt_d   = '0;
          len_d   = ta_len;
        end else if (unit_tick) begin
          cnt_d = cnt_q + 1'b1;
        end
        default: begin
          state_d = PH_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  assign gate_d = (state_d == PH_HIGH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
      len_q   <= PHASE_W'(1) << FIELD_W;
      gate_q  <= 1'b0;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      len_q   <= len_d;
      gate_q  <= gate_d;
      rise_q  <= gate_d & ~gate_q;
      fall_q  <= ~gate_d & gate_q;
    end
  end

  assign gate      = gate_q;
  assign gate_rise = rise_q;
  assign gate_fall = fall_q;

  // R2 R3: the unit counter stays inside the latched phase length
  a_r2_cnt_below_len: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < len_q);
  // R7: a stopped generator drives the gate low on the next cycle
  a_r7_stop_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !gate_q);
  // R6: the gate only rises right after a unit boundary
  a_r6_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_q) |-> $past(unit_tick));
  // R8 R9: the latched length does not move inside a running phase
  a_r8_len_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != PH_IDLE && state_q == $past(state_q)) |-> $stable(len_q));
  // R10: the edge pulses are single-cycle and match the level
  a_r10_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    gate_rise |=> !gate_rise);
  a_r10_rise_level: assert property (@(posedge clk) disable iff (!rst_n)
    gate_rise |-> gate_q);
  a_r10_fall_level: assert property (@(posedge clk) disable iff (!rst_n)
    gate_fall |-> !gate_q);

endmodule

// File: rtl/wgate_gen.sv
module wgate_gen #(
  parameter int BASE_SHIFT = 12,
  parameter int NUM_TAPS   = 3,
  parameter int SEL_W      = 2,
  parameter int FIELD_W    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               src_tick,
  input  logic [SEL_W-1:0]   tap_sel,
  input  logic               run,
  input  logic [FIELD_W-1:0] ta_val,
  input  logic               ta_wr,
  input  logic [FIELD_W-1:0] tb_val,
  input  logic               tb_wr,
  output logic               gate,
  output logic               gate_rise,
  output logic               gate_fall
);

  logic               unit_tick;
  logic [FIELD_W-1:0] ta_q, tb_q;

  wgate_prescaler #(
    .BASE_SHIFT(BASE_SHIFT), .NUM_TAPS(NUM_TAPS), .SEL_W(SEL_W)
  ) u_pre (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick),
    .tap_sel(tap_sel), .unit_tick(unit_tick)
  );

  wgate_cfg #(.FIELD_W(FIELD_W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .ta_val(ta_val), .ta_wr(ta_wr), .tb_val(tb_val), .tb_wr(tb_wr),
    .ta_q(ta_q), .tb_q(tb_q)
  );

  wgate_phase_seq #(.FIELD_W(FIELD_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .run(run), .unit_tick(unit_tick),
    .ta_q(ta_q), .tb_q(tb_q),
    .gate(gate), .gate_rise(gate_rise), .gate_fall(gate_fall)
  );

endmodule

// File: tb/wgate_gen_test.sv
module wgate_gen_test;

  localparam int B     = 2;
  localparam int LIMIT = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       src_tick;
  logic [1:0] tap_sel = 2'd0;
  logic       run = 1'b0;
  logic [3:0] ta_val = 4'd0;
  logic       ta_wr = 1'b0;
  logic [3:0] tb_val = 4'd0;
  logic       tb_wr = 1'b0;
  logic       gate, gate_rise, gate_fall;

  int  cyc = 0;
  bit  timed_out = 1'b0;
  int  n_checks = 0;
  int  n_fail = 0;
  int  rise_cnt = 0;
  int  pulse_bad = 0;
  logic prev_gate = 1'b0;
  int  per_r = 1;
  int  ph = 0;

  wgate_gen #(.BASE_SHIFT(B)) uut (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .tap_sel(tap_sel),
    .run(run), .ta_val(ta_val), .ta_wr(ta_wr), .tb_val(tb_val),
    .tb_wr(tb_wr), .gate(gate), .gate_rise(gate_rise), .gate_fall(gate_fall)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    ph <= (ph + 1 >= per_r) ? 0 : ph + 1;
    cyc = cyc + 1;
    if (cyc > LIMIT) timed_out = 1'b1;
  end
  assign src_tick = (ph == 0);

  // R10 monitor: pulses against level changes seen at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (gate_rise) rise_cnt = rise_cnt + 1;
      if (gate_rise != (gate && !prev_gate) || gate_fall != (!gate && prev_gate))
        pulse_bad = pulse_bad + 1;
      prev_gate = gate;
    end
  end

  // vector: tap(2) ta(4) tb(4) source period(2)
  localparam logic [11:0] VEC [7] = '{
    {2'd0, 4'd0,  4'd15, 2'd1},
    {2'd1, 4'd10, 4'd3,  2'd1},
    {2'd2, 4'd15, 4'd15, 2'd1},
    {2'd3, 4'd14, 4'd12, 2'd1},
    {2'd0, 4'd8,  4'd4,  2'd2},
    {2'd1, 4'd0,  4'd0,  2'd2},
    {2'd0, 4'd15, 4'd0,  2'd1}
  };

  function automatic int unit_cycles(int tap, int per);
    int t;
    t = (tap > 2) ? 2 : tap;
    return (2 ** (B + t)) * per;
  endfunction

  function automatic int expect_len(int field, int tap, int per);
    return (16 - field) * unit_cycles(tap, per);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_pulse(input bit want_rise, output int t);
    forever begin
      @(negedge clk);
      if (timed_out) break;
      if (want_rise ? gate_rise : gate_fall) break;
    end
    t = cyc;
  endtask

  task automatic configure(input int tap, input int ta, input int tb, input int per);
    @(negedge clk);
    run = 1'b0;
    per_r = per;
    tap_sel = 2'(tap);
    ta_val = 4'(ta);
    tb_val = 4'(tb);
    ta_wr = 1'b1;
    tb_wr = 1'b1;
    @(negedge clk);
    ta_wr = 1'b0;
    tb_wr = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int t0, t1, t2, t3, t4, t5, t6, t7, rc;
    repeat (4) @(negedge clk);
    check(gate == 0 && gate_rise == 0 && gate_fall == 0, "R1 in reset",
          {gate, gate_rise, gate_fall}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(gate == 0 && gate_rise == 0 && gate_fall == 0, "R1 after release",
          {gate, gate_rise, gate_fall}, 0);
    repeat (60) @(negedge clk);
    check(rise_cnt == 0 && gate == 0, "R7 idle with run low", rise_cnt, 0);

    for (int i = 0; i < 7; i++) begin
      int tap, ta, tb, per, u;
      tap = int'(VEC[i][11:10]);
      ta  = int'(VEC[i][9:6]);
      tb  = int'(VEC[i][5:2]);
      per = int'(VEC[i][1:0]);
      u   = unit_cycles(tap, per);
      configure(tap, ta, tb, per);
      run = 1'b1;
      t0 = cyc;
      wait_pulse(1'b1, t1);
      check(t1 - t0 >= 1 && t1 - t0 <= u, "R6 start latency", t1 - t0, u);
      wait_pulse(1'b0, t2);
      wait_pulse(1'b1, t3);
      check(t2 - t1 == expect_len(ta, tap, per),
            per == 2 ? "R2 R5 high length" : "R2 R4 high length",
            t2 - t1, expect_len(ta, tap, per));
      check(t3 - t2 == expect_len(tb, tap, per),
            per == 2 ? "R3 R5 low length" : "R3 R4 low length",
            t3 - t2, expect_len(tb, tap, per));
    end

    // Mid-phase writes: unit 4 cycles, high 16, low 8
    configure(0, 12, 14, 1);
    run = 1'b1;
    wait_pulse(1'b1, t1);
    repeat (3) @(negedge clk);
    ta_val = 4'd8; ta_wr = 1'b1;
    @(negedge clk);
    ta_wr = 1'b0;
    wait_pulse(1'b0, t2);
    check(t2 - t1 == 16, "R8 running high kept", t2 - t1, 16);
    wait_pulse(1'b1, t3);
    wait_pulse(1'b0, t4);
    check(t4 - t3 == 32, "R8 next high uses new Ta", t4 - t3, 32);
    repeat (2) @(negedge clk);
    tb_val = 4'd10; tb_wr = 1'b1;
    @(negedge clk);
    tb_wr = 1'b0;
    wait_pulse(1'b1, t5);
    check(t5 - t4 == 8, "R9 running low kept", t5 - t4, 8);
    wait_pulse(1'b0, t6);
    wait_pulse(1'b1, t7);
    check(t7 - t6 == 24, "R9 next low uses new Tb", t7 - t6, 24);

    // Stop in the middle of a high phase
    repeat (3) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    check(gate == 0 && gate_fall == 1, "R7 stop forces fall",
          {gate, gate_fall}, 1);
    rc = rise_cnt;
    repeat (200) @(negedge clk);
    check(rise_cnt == rc && gate == 0, "R7 no rise while stopped", rise_cnt, rc);

    check(pulse_bad == 0, "R10 pulse alignment", pulse_bad, 0);
    check(!timed_out, "watchdog", int'(timed_out), 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule